// File: doc/BRIEF.md
# Block-Read Memory Controller with Selectable Organisation

This controller sits on the memory side of a cache refill path. It receives the address of a four-word block, models the delay of the storage array, and returns the block to the requester. One parameter picks how the storage is organised, and the timing follows from that choice. In the serial organisation a single one-word array is read four times in a row. In the wide organisation one access produces all four words together. In the banked organisation four one-word banks are read at the same time and their words leave one after another.

The storage is modelled as four register arrays, one per word lane. Word address `{block, k}` lives in lane `k`. At reset the arrays are loaded with a fixed computed pattern, so any block can be read back and checked. Only one request is handled at a time. The response carries one data lane per word and a four-bit lane mask, so one cycle can carry either a single word or the whole block.

Top module: `blkmem_ctl`

## Requirements
Cycle numbering: cycle 1 is the clock cycle that follows the edge at which `req_valid && req_ready` is seen. A cycle count for a block is the cycle in which `rsp_done` is high.
- R1: While reset is held and after it is released, `req_ready` is 1 and `rsp_valid`, `rsp_done` and `rsp_mask` are 0.
- R2: `req_ready` is 0 from cycle 1 through the done cycle and is 1 in the cycle after. A `req_valid` raised while `req_ready` is 0 is ignored: no second block is returned, and the block in progress keeps its data.
- R3: With `ORG = ORG_SERIAL` and an access latency of 15, word k appears alone in cycle 17 + 16·k, and the block completes in cycle 65.
- R4: With `ORG = ORG_WIDE`, all four lanes are presented together in cycle 17, and the block completes in that cycle.
- R5: With `ORG = ORG_INTERLEAVE`, lanes 0, 1, 2 and 3 are presented in ascending order in cycles 17, 18, 19 and 20, and the block completes in cycle 20.
- R6: Lane k of `rsp_data` (bits `[32k+31:32k]`) carries the word at word address `A = 4·block + k`. After reset that word holds `(A × 0x9E3779B9) XOR 0x0F0F5A5A`, truncated to 32 bits.
- R7: `rsp_valid` equals the OR of `rsp_mask`. A lane whose mask bit is 0 reads as zero.
- R8: `rsp_done` is a single-cycle pulse in the cycle that presents the last word. Exactly four words are delivered per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also loads the storage pattern |
| req_valid | input | 1 | Block request strobe |
| req_blk | input | BLK_W | Block address of the request |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | At least one lane is being presented |
| rsp_mask | output | 4 | One bit per lane being presented this cycle |
| rsp_data | output | 4·DATA_W | Four word lanes, lane k at bits [DATA_W·k +: DATA_W] |
| rsp_done | output | 1 | Pulses in the cycle of the final word |

## Verification
Each result has a fixed due cycle counted from the accepting edge. Serial words are due at cycles 17, 33, 49 and 65. Wide words are all due at cycle 17. Banked words are due at cycles 17 to 20. `req_ready` returns high one cycle after done. The bench drives each request at a falling edge and samples every output at each later falling edge. It numbers those samples 1, 2, ... so that sample c is cycle c, and compares each lane's arrival cycle, data and the done cycle against the values it derives itself for that organisation. The checker counts cycles after acceptance on its own counter and ties the done pulse to the organisation's block total.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;

  typedef enum logic [1:0] {
    ORG_SERIAL     = 2'd0,
    ORG_WIDE       = 2'd1,
    ORG_INTERLEAVE = 2'd2
  } org_e;

  localparam int unsigned WORDS = 4;
  localparam int unsigned LANE_W = 2;

  // Cycle (1-based after acceptance) in which lane k is on the bus.
  // One address cycle and one transfer cycle per bus beat are built in.
  function automatic int unsigned lane_xfer_cycle(org_e org, int unsigned lat,
                                                  int unsigned lane);
    int unsigned c;
    case (org)
      ORG_SERIAL: c = (lane + 1) * (lat + 1) + 1;
      ORG_WIDE:   c = lat + 2;
      default:    c = lat + 2 + lane;
    endcase
    return c;
  endfunction

  // Cycle in which the block is complete.
  function automatic int unsigned blk_total(org_e org, int unsigned lat);
    return lane_xfer_cycle(org, lat, WORDS - 1);
  endfunction

  // Power-on contents of a word address.
  function automatic logic [31:0] init_word(int unsigned waddr);
    logic [31:0] a;
    a = waddr;
    return (a * 32'h9E37_79B9) ^ 32'h0F0F_5A5A;
  endfunction

endpackage

// File: rtl/blkmem_bank.sv
module blkmem_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned LANE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic              fetch,
  output logic [DATA_W-1:0] rd_word
);
  localparam int unsigned DEPTH = 1 << BLK_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // Contents are a computed pattern loaded at reset; the array is read-only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        store[i] <= DATA_W'(blkmem_pkg::init_word(i * blkmem_pkg::WORDS + LANE));
      end
    end
  end

  // Sense register: captured on the last cycle of this bank's access.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (fetch) begin
      rd_q <= store[rd_blk];
    end
  end

  assign rd_word = rd_q;
endmodule

// File: rtl/blkmem_seq.sv
module blkmem_seq #(
  parameter blkmem_pkg::org_e ORG = blkmem_pkg::ORG_INTERLEAVE,
  parameter int unsigned ACCESS_LAT = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  output logic       busy,
  output logic [3:0] acc_strobe,
  output logic [3:0] xfer_mask,
  output logic       last_beat
);
  localparam int unsigned TOTAL = blkmem_pkg::blk_total(ORG, ACCESS_LAT);
  localparam int unsigned CYC_W = $clog2(TOTAL + 1);

  logic [CYC_W-1:0] cyc;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cyc    <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cyc    <= CYC_W'(1);
    end else if (busy_q) begin
      if (cyc == CYC_W'(TOTAL)) begin
        busy_q <= 1'b0;
        cyc    <= '0;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    localparam int unsigned XC = blkmem_pkg::lane_xfer_cycle(ORG, ACCESS_LAT, k);
    assign acc_strobe[k] = busy_q && (cyc == CYC_W'(XC - 1));
    assign xfer_mask[k]  = busy_q && (cyc == CYC_W'(XC));
  end

  assign busy      = busy_q;
  assign last_beat = busy_q && (cyc == CYC_W'(TOTAL));
endmodule

// File: rtl/blkmem_ctl.sv
module blkmem_ctl #(
  parameter blkmem_pkg::org_e ORG = blkmem_pkg::ORG_INTERLEAVE,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BLK_W      = 4,
  parameter int unsigned ACCESS_LAT = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [BLK_W-1:0]    req_blk,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [3:0]          rsp_mask,
  output logic [4*DATA_W-1:0] rsp_data,
  output logic                rsp_done
);
  logic             accept;
  logic             busy;
  logic [3:0]       acc_strobe;
  logic [3:0]       xfer_mask;
  logic             last_beat;
  logic [BLK_W-1:0] blk_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (accept) begin
      blk_q <= req_blk;
    end
  end

  blkmem_seq #(.ORG(ORG), .ACCESS_LAT(ACCESS_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .busy       (busy),
    .acc_strobe (acc_strobe),
    .xfer_mask  (xfer_mask),
    .last_beat  (last_beat)
  );

  for (genvar k = 0; k < 4; k++) begin : g_bank
    logic [DATA_W-1:0] word;
    blkmem_bank #(.DATA_W(DATA_W), .BLK_W(BLK_W), .LANE(k)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_blk  (blk_q),
      .fetch   (acc_strobe[k]),
      .rd_word (word)
    );
    assign rsp_data[k*DATA_W +: DATA_W] = xfer_mask[k] ? word : '0;
  end

  assign rsp_mask  = xfer_mask;
  assign rsp_valid = |xfer_mask;
  assign rsp_done  = last_beat;
endmodule

// File: rtl/blkmem_ctl_chk.sv
module blkmem_ctl_chk #(
  parameter blkmem_pkg::org_e ORG = blkmem_pkg::ORG_INTERLEAVE,
  parameter int unsigned ACCESS_LAT = 15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [3:0] rsp_mask,
  input logic       rsp_done,
  input logic [3:0] acc_strobe
);
  localparam int unsigned TOTAL = blkmem_pkg::blk_total(ORG, ACCESS_LAT);

  // Independent cycle counter since acceptance.
  logic [15:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (req_valid && req_ready) since <= 16'd1;
    else if (rsp_done) since <= '0;
    else if (since != 0) since <= since + 16'd1;
  end

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 0) |-> (req_ready && !rsp_valid && !rsp_done));

  p_hold_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_reopen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready);

  p_done_total_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (since == 16'(TOTAL)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_valid_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_mask != 4'd0));

  p_fetch_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe != 4'd0) |=> (rsp_mask == $past(acc_strobe)));

  if (ORG == blkmem_pkg::ORG_SERIAL) begin : g_ser
    p_single_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_mask));
  end else if (ORG == blkmem_pkg::ORG_WIDE) begin : g_wide
    p_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_mask == 4'hF && rsp_done));
  end else begin : g_il
    for (genvar k = 0; k < 3; k++) begin : g_step
      p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mask[k] |=> rsp_mask[k+1]);
    end
    p_single_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_mask));
  end
endmodule

bind blkmem_ctl blkmem_ctl_chk #(.ORG(ORG), .ACCESS_LAT(ACCESS_LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_mask   (rsp_mask),
  .rsp_done   (rsp_done),
  .acc_strobe (acc_strobe)
);

// File: tb/tb_blkmem_ctl.sv
module tb_blkmem_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // Vector: [5:4] organisation (0 serial, 1 wide, 2 banked), [3:0] block.
  localparam logic [5:0] VEC [NV] = '{
    6'h00, 6'h0F, 6'h05, 6'h10, 6'h1A, 6'h13, 6'h20, 6'h2F, 6'h29
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         req_v [3];
  logic [3:0]   req_b [3];
  logic         rdy   [3];
  logic         vld   [3];
  logic [3:0]   msk   [3];
  logic [127:0] dat   [3];
  logic         dn    [3];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  blkmem_ctl #(.ORG(blkmem_pkg::ORG_SERIAL)) dut_ser (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[0]), .req_blk(req_b[0]),
    .req_ready(rdy[0]), .rsp_valid(vld[0]), .rsp_mask(msk[0]),
    .rsp_data(dat[0]), .rsp_done(dn[0]));
  blkmem_ctl #(.ORG(blkmem_pkg::ORG_WIDE)) dut_wide (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[1]), .req_blk(req_b[1]),
    .req_ready(rdy[1]), .rsp_valid(vld[1]), .rsp_mask(msk[1]),
    .rsp_data(dat[1]), .rsp_done(dn[1]));
  blkmem_ctl #(.ORG(blkmem_pkg::ORG_INTERLEAVE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[2]), .req_blk(req_b[2]),
    .req_ready(rdy[2]), .rsp_valid(vld[2]), .rsp_mask(msk[2]),
    .rsp_data(dat[2]), .rsp_done(dn[2]));

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int due_cycle(int m, int k);
    if (m == 0) return 17 + 16 * k;   // serial
    if (m == 1) return 17;            // wide
    return 17 + k;                    // banked
  endfunction

  function automatic int block_cycles(int m);
    return (m == 0) ? 65 : (m == 1) ? 17 : 20;
  endfunction

  function automatic logic [31:0] expect_word(int b, int k);
    logic [31:0] wa;
    logic [31:0] prod;
    wa = 32'(b) * 32'd4 + 32'(k);
    prod = wa * 32'h9E37_79B9;
    return prod ^ 32'h0F0F_5A5A;
  endfunction

  function automatic string mode_tag(int m);
    return (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
  endfunction

  task automatic run_blk(int m, int b, bit inject);
    int c;
    int seen;
    int done_c;
    @(negedge clk);
    chk(rdy[m] == 1'b1, "R2 ready before request", rdy[m], 1);
    req_v[m] = 1'b1;
    req_b[m] = 4'(b);
    @(negedge clk);
    req_v[m] = 1'b0;
    c = 1; seen = 0; done_c = 0;
    while (done_c == 0 && c < 100) begin
      if (rdy[m]) chk(0, "R2 ready low while busy", rdy[m], 0);
      if (inject && c == 5) begin req_v[m] = 1'b1; req_b[m] = ~4'(b); end
      if (inject && c == 6) req_v[m] = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (msk[m][k]) begin
          seen++;
          chk(c == due_cycle(m, k), {mode_tag(m), " lane cycle"}, c, due_cycle(m, k));
          chk(dat[m][32*k +: 32] == expect_word(b, k), "R6 lane data",
              dat[m][32*k +: 32], expect_word(b, k));
        end else if (dat[m][32*k +: 32] != 32'd0) begin
          chk(0, "R7 idle lane nonzero", dat[m][32*k +: 32], 0);
        end
      end
      if (vld[m] != (msk[m] != 4'd0)) chk(0, "R7 valid vs mask", vld[m], msk[m] != 4'd0);
      if (dn[m]) done_c = c;
      else begin @(negedge clk); c++; end
    end
    chk(done_c == block_cycles(m), {mode_tag(m), " R8 done cycle"}, done_c, block_cycles(m));
    chk(seen == 4, "R8 word count", seen, 4);
    @(negedge clk);
    chk(rdy[m] == 1'b1, "R2 ready after done", rdy[m], 1);
    chk(dn[m] == 1'b0, "R8 done single cycle", dn[m], 0);
    if (inject) begin
      int extra = 0;
      for (int i = 0; i < 30; i++) begin
        if (vld[m]) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R2 busy request ignored", extra, 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin req_v[m] = 1'b0; req_b[m] = 4'd0; end
    repeat (3) @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      chk(rdy[m] && !vld[m] && !dn[m] && msk[m] == 4'd0, "R1 state in reset",
          {rdy[m], vld[m], dn[m]}, 3'b100);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      chk(rdy[m] && !vld[m] && !dn[m], "R1 state after reset",
          {rdy[m], vld[m], dn[m]}, 3'b100);
    end
    for (int i = 0; i < NV; i++) begin
      run_blk(int'(VEC[i][5:4]), int'(VEC[i][3:0]), 1'b0);
    end
    // Corner cases: request raised mid-block must be dropped, in each mode.
    run_blk(2, 1, 1'b1);
    run_blk(0, 6, 1'b1);
    run_blk(1, 12, 1'b1);
    // Back-to-back: the next request right after ready returns.
    run_blk(2, 14, 1'b0);
    run_blk(2, 3, 1'b0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule